// File: doc/BRIEF.md
# OTP Array Program-and-Verify Sequencer

This block drives a byte-wide one-time-programmable array through a complete programming run. After a start strobe it steps through the locations from address zero upward. For each location it fetches the intended byte from a data source port, raises the program supply and applies timed program pulses. After every pulse it reads the location back. If the byte does not match, it applies another pulse. If the byte still does not match when the per-address pulse budget is used up, the run stops with a failure.

Cells start erased at all ones, and programming can only clear bits. A location whose target byte is all ones therefore needs no pulse and is passed over. When the last location has been handled, a second pass reads every location back and compares it with the source data. A mismatch in that pass also stops the run with a failure.

All timing is counted in microsecond ticks supplied from outside. This covers setup, pulse width, data hold and recovery. The read-back is sampled only after a programmable number of clock cycles with the read enables asserted, so the array's access time is respected.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, or after a reset applied in the middle of a run, `mem_vpp_o`, `mem_pgm_o`, `mem_ce_o`, `mem_oe_o`, `done_o` and `fail_o` are all low, and the sequencer waits for `start_i`.
- R2: A one-cycle `start_i` begins a run at address 0. Program pulses are issued to addresses in non-decreasing order.
- R3: `mem_pgm_o` is high only while `mem_vpp_o` is high. Each pulse lasts at least `PULSE_US` microsecond ticks.
- R4: `mem_vpp_o` is high with address and write data stable for at least `SETUP_US` ticks before a pulse rises. Address and data stay unchanged for the whole time `mem_vpp_o` is high, which covers the `HOLD_US` ticks after the pulse. `mem_vpp_o` then stays low for `RECOV_US` ticks before the read.
- R5: After each pulse the same address is read with `mem_ce_o` and `mem_oe_o` high. `mem_rdata_i` is sampled no earlier than `ACCESS_CYC` clock cycles after both enables rise, or after the address changes while they are high.
- R6: A read-back that differs from the target causes another pulse. A match moves the sequencer to the next address. Each address therefore receives exactly as many pulses as its cells need.
- R7: If `MAX_PULSES` pulses have been applied and the read-back still mismatches, `fail_o` rises and `fail_addr_o` holds that address. No further pulses follow. Both outputs hold until the next `start_i`.
- R8: A location whose source byte is 8'hFF receives no pulse.
- R9: After the last address, every location is read back and compared with `src_data_i`. The first mismatch sets `fail_o` with that address in `fail_addr_o`.
- R10: A run that completes without mismatch raises `done_o`, which stays high until the next `start_i`. `done_o` and `fail_o` are never high together.
- R11: A read-back that matches after the `MAX_PULSES`-th pulse counts as success for that address.
- R12: `mem_ce_o` and `mem_oe_o` are low whenever `mem_vpp_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that begins a run |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| src_addr_o | output | ADDR_W | Address requested from the data source |
| src_data_i | input | DATA_W | Intended byte for `src_addr_o`, valid in the same cycle |
| mem_addr_o | output | ADDR_W | Array address |
| mem_wdata_o | output | DATA_W | Byte driven for programming |
| mem_rdata_i | input | DATA_W | Array read data |
| mem_ce_o | output | 1 | Array select for reads |
| mem_oe_o | output | 1 | Array output enable |
| mem_vpp_o | output | 1 | Program supply enable |
| mem_pgm_o | output | 1 | Program pulse |
| done_o | output | 1 | Run completed with every location verified |
| fail_o | output | 1 | Run stopped on a failure |
| fail_addr_o | output | ADDR_W | Address that failed |

## Verification
Two events can fall on the same read-back: the pulse budget reaching its limit and the byte finally matching. One table entry gives an address a cell model that needs exactly `MAX_PULSES` pulses, so the match and the exhausted budget coincide. The bench then expects `done_o`, not `fail_o`, and expects exactly `MAX_PULSES` pulses at that address. The neighbouring entry needs one pulse more, which must give `fail_o` with that address and no pulses beyond it. Together the two entries separate the two outcomes.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SETUP, S_PULSE, S_HOLD, S_RECOV,
    S_READ, S_NEXT, S_FREAD, S_DONE, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/otp_delay_cnt.sv
module otp_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         step_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= len_i;
    else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/otp_pulse_budget.sv
module otp_pulse_budget #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  logic [PW-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     used_q <= '0;
    else if (clr_i)  used_q <= '0;
    else if (inc_i && !limit_o) used_q <= used_q + 1'b1;
  end

  assign limit_o = (used_q >= PW'(MAX_PULSES));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PULSE_US   = 75,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int RECOV_US   = 2,
  parameter int MAX_PULSES = 25,
  parameter int ACCESS_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              us_tick_i,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_ce_o,
  output logic              mem_oe_o,
  output logic              mem_vpp_o,
  output logic              mem_pgm_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  localparam int US_MAX = (PULSE_US > SETUP_US ? PULSE_US : SETUP_US) >
                          (HOLD_US > RECOV_US ? HOLD_US : RECOV_US) ?
                          (PULSE_US > SETUP_US ? PULSE_US : SETUP_US) :
                          (HOLD_US > RECOV_US ? HOLD_US : RECOV_US);
  localparam int US_W  = $clog2(US_MAX + 1);
  localparam int ACC_W = $clog2(ACCESS_CYC + 2);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, fail_addr_q;
  logic [DATA_W-1:0] tgt_q;
  logic              addr_clr, addr_inc, tgt_ld, fail_set;
  logic              us_load, acc_load, pulse_clr, pulse_inc;
  logic [US_W-1:0]   us_len;
  logic              us_done, acc_done, budget_out;
  logic              is_last;

  assign is_last = (addr_q == LAST_ADDR);

  otp_delay_cnt #(.W(US_W)) u_us_timer (
    .clk_i, .rst_ni, .load_i(us_load), .len_i(us_len),
    .step_i(us_tick_i), .done_o(us_done)
  );

  otp_delay_cnt #(.W(ACC_W)) u_acc_timer (
    .clk_i, .rst_ni, .load_i(acc_load), .len_i(ACC_W'(ACCESS_CYC)),
    .step_i(1'b1), .done_o(acc_done)
  );

  otp_pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_budget (
    .clk_i, .rst_ni, .clr_i(pulse_clr), .inc_i(pulse_inc), .limit_o(budget_out)
  );

  always_comb begin
    state_d   = state_q;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    tgt_ld    = 1'b0;
    fail_set  = 1'b0;
    us_load   = 1'b0;
    us_len    = '0;
    acc_load  = 1'b0;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start_i) begin
        addr_clr = 1'b1;
        state_d  = S_LOAD;
      end
      S_LOAD: begin
        tgt_ld = 1'b1;
        if (&src_data_i) state_d = S_NEXT;  // erased already: skip
        else begin
          pulse_clr = 1'b1;
          us_load   = 1'b1;
          us_len    = US_W'(SETUP_US);
          state_d   = S_SETUP;
        end
      end
      S_SETUP: if (us_done) begin
        us_load = 1'b1;
        us_len  = US_W'(PULSE_US);
        state_d = S_PULSE;
      end
      S_PULSE: if (us_done) begin
        pulse_inc = 1'b1;
        us_load   = 1'b1;
        us_len    = US_W'(HOLD_US);
        state_d   = S_HOLD;
      end
      S_HOLD: if (us_done) begin
        us_load = 1'b1;
        us_len  = US_W'(RECOV_US);
        state_d = S_RECOV;
      end
      S_RECOV: if (us_done) begin
        acc_load = 1'b1;
        state_d  = S_READ;
      end
      S_READ: if (acc_done) begin
        // match takes priority over an exhausted budget
        if (mem_rdata_i == tgt_q) state_d = S_NEXT;
        else if (budget_out) begin
          fail_set = 1'b1;
          state_d  = S_FAIL;
        end else begin
          us_load = 1'b1;
          us_len  = US_W'(SETUP_US);
          state_d = S_SETUP;
        end
      end
      S_NEXT: begin
        if (is_last) begin
          addr_clr = 1'b1;
          acc_load = 1'b1;
          state_d  = S_FREAD;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_LOAD;
        end
      end
      S_FREAD: if (acc_done) begin
        if (mem_rdata_i != src_data_i) begin
          fail_set = 1'b1;
          state_d  = S_FAIL;
        end else if (is_last) state_d = S_DONE;
        else begin
          addr_inc = 1'b1;
          acc_load = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      tgt_q       <= '1;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_clr)      addr_q <= '0;
      else if (addr_inc) addr_q <= addr_q + 1'b1;
      if (tgt_ld)        tgt_q <= src_data_i;
      if (fail_set)      fail_addr_q <= addr_q;
    end
  end

  assign src_addr_o  = addr_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = tgt_q;
  assign mem_vpp_o   = (state_q == S_SETUP) || (state_q == S_PULSE) || (state_q == S_HOLD);
  assign mem_pgm_o   = (state_q == S_PULSE);
  assign mem_ce_o    = (state_q == S_READ) || (state_q == S_FREAD);
  assign mem_oe_o    = mem_ce_o;
  assign done_o      = (state_q == S_DONE);
  assign fail_o      = (state_q == S_FAIL);
  assign fail_addr_o = fail_addr_q;
endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PULSE_US = 75,
  parameter int SETUP_US = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              us_tick_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ce_o,
  input logic              mem_oe_o,
  input logic              mem_vpp_o,
  input logic              mem_pgm_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o
);
  int unsigned pw_ticks, su_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_ticks <= 0;
      su_ticks <= 0;
    end else begin
      if (!mem_pgm_o)     pw_ticks <= 0;
      else if (us_tick_i) pw_ticks <= pw_ticks + 1;
      if (!mem_vpp_o)     su_ticks <= 0;
      else if (!mem_pgm_o && us_tick_i) su_ticks <= su_ticks + 1;
    end
  end

  assert_pgm_under_vpp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_pgm_o |-> mem_vpp_o);
  assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_pgm_o) |-> pw_ticks >= PULSE_US);
  assert_setup_time_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_pgm_o) |-> su_ticks >= SETUP_US);
  assert_prog_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vpp_o && $past(mem_vpp_o) |-> $stable(mem_addr_o) && $stable(mem_wdata_o));
  assert_no_read_in_prog_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vpp_o |-> !mem_oe_o && !mem_ce_o);
  assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o && $stable(fail_addr_o));
  assert_fail_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !mem_vpp_o);
  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  assert_done_fail_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
endmodule

bind otp_prog_seq otp_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_US(PULSE_US), .SETUP_US(SETUP_US)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .us_tick_i(us_tick_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ce_o(mem_ce_o),
  .mem_oe_o(mem_oe_o), .mem_vpp_o(mem_vpp_o), .mem_pgm_o(mem_pgm_o),
  .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o)
);

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;
  localparam int AW = 3, DW = 8, NLOC = 8;
  localparam int PULSE = 75, SETUP = 2, MAXP = 4, ACC = 3;
  localparam int WD_RUN = 30000;

  typedef struct packed {
    logic [63:0] tgt;    // byte a = target of address a
    logic [31:0] need;   // nibble a = pulses the cells of address a need
    logic [63:0] pre;    // array content before the run
    logic        exp_fail;
    logic        exp_final;
    logic [2:0]  exp_addr;
  } case_t;

  localparam case_t CASES [5] = '{
    '{64'h00A5FF3C12FF807E, 32'h12131121, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 3'd0},
    '{64'h1122334455667788, 32'h11411111, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 3'd0},
    '{64'hF0F0F0F00F0F0F0F, 32'h11115111, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 3'd3},
    '{64'h01FF030405060708, 32'h11111111, 64'hFF7FFFFFFFFFFFFF, 1'b1, 1'b1, 3'd6},
    '{64'hFFFFFFFFFFFFFFFF, 32'h11111111, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 3'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, us_tick = 0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic ce, oe, vpp, pgm, done, fail;

  always #4 clk = ~clk;

  otp_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PULSE_US(PULSE), .SETUP_US(SETUP), .HOLD_US(2),
    .RECOV_US(2), .MAX_PULSES(MAXP), .ACCESS_CYC(ACC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .us_tick_i(us_tick),
    .src_addr_o(src_addr), .src_data_i(src_data), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ce_o(ce), .mem_oe_o(oe),
    .mem_vpp_o(vpp), .mem_pgm_o(pgm), .done_o(done), .fail_o(fail),
    .fail_addr_o(fail_addr)
  );

  // microsecond tick every 4 clocks
  int div = 0;
  always @(posedge clk) begin
    div     <= (div == 3) ? 0 : div + 1;
    us_tick <= (div == 3);
  end

  // array model
  case_t cur;
  logic  model_init = 0;
  logic [DW-1:0] mem [NLOC];
  int pcnt [NLOC];
  int acc_cnt, pw, su, last_pa, order_err, v3, v4, v12;
  logic pgm_q, vpp_q;
  logic [AW-1:0] last_a;
  logic [DW-1:0] wd_q;

  assign src_data  = cur.tgt[src_addr*8 +: 8];
  // early sampling sees the complement and never matches
  assign mem_rdata = (ce && oe && acc_cnt >= ACC) ? mem[mem_addr] : ~mem[mem_addr];

  always @(posedge clk) begin
    if (model_init) begin
      for (int a = 0; a < NLOC; a++) begin
        mem[a]  <= cur.pre[a*8 +: 8];
        pcnt[a] <= 0;
      end
      last_pa <= 0; order_err <= 0; v3 <= 0; v4 <= 0; v12 <= 0;
      acc_cnt <= 0; pw <= 0; su <= 0;
    end else begin
      if (!(ce && oe))          acc_cnt <= 0;
      else if (mem_addr != last_a) acc_cnt <= 1;
      else                      acc_cnt <= acc_cnt + 1;
      pw <= pgm ? pw + (us_tick ? 1 : 0) : 0;
      su <= (vpp && !pgm) ? su + (us_tick ? 1 : 0) : (vpp ? su : 0);
      if (pgm && !pgm_q) begin
        if (int'(mem_addr) < last_pa) order_err <= order_err + 1;
        last_pa <= int'(mem_addr);
        if (su < SETUP || !vpp) v4 <= v4 + 1;
        pcnt[mem_addr] <= pcnt[mem_addr] + 1;
        if (pcnt[mem_addr] + 1 >= int'(cur.need[mem_addr*4 +: 4]))
          mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      end
      if (!pgm && pgm_q && pw < PULSE) v3 <= v3 + 1;
      if (pgm && !vpp) v3 <= v3 + 1;
      if (vpp && vpp_q && (mem_addr != last_a || mem_wdata != wd_q)) v4 <= v4 + 1;
      if (vpp && (ce || oe)) v12 <= v12 + 1;
    end
    last_a <= mem_addr; wd_q <= mem_wdata; pgm_q <= pgm; vpp_q <= vpp;
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int k);
    int cyc = 0;
    int stop;
    int ep;
    cur = CASES[k];
    @(negedge clk) model_init = 1;
    @(negedge clk) model_init = 0; start = 1;
    @(negedge clk) start = 0;
    while (!(done || fail) && cyc < WD_RUN) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= WD_RUN) begin
      n_err++;
      $display("FAIL watchdog case %0d: actual hung expected finish", k);
    end
    repeat (3) @(negedge clk);
    chk("R7 R9 R10 fail_o", int'(fail), int'(cur.exp_fail));
    chk("R10 done_o", int'(done), int'(!cur.exp_fail));
    if (cur.exp_fail) chk(cur.exp_final ? "R9 fail_addr" : "R7 fail_addr",
                          int'(fail_addr), int'(cur.exp_addr));
    stop = (cur.exp_fail && !cur.exp_final) ? int'(cur.exp_addr) : NLOC;
    for (int a = 0; a < NLOC; a++) begin
      int nd = int'(cur.need[a*4 +: 4]);
      if (a > stop || cur.tgt[a*8 +: 8] == 8'hFF) ep = 0;
      else ep = (nd > MAXP) ? MAXP : nd;
      if (cur.tgt[a*8 +: 8] == 8'hFF)  chk("R8 skip all-ones", pcnt[a], ep);
      else if (nd == MAXP)            chk("R11 last-pulse match", pcnt[a], ep);
      else                            chk("R5 R6 pulse count", pcnt[a], ep);
    end
    chk("R2 address order", order_err, 0);
    chk("R3 pulse width", v3, 0);
    chk("R4 setup and stability", v4, 0);
    chk("R12 no read during program", v12, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cur = CASES[0];
    repeat (3) @(negedge clk);
    chk("R1 reset vpp", int'(vpp), 0);
    chk("R1 reset pgm", int'(pgm), 0);
    chk("R1 reset oe", int'(oe), 0);
    chk("R1 reset done/fail", int'(done | fail), 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R1 idle without start", int'(vpp | done | fail), 0);
    for (int k = 0; k < 5; k++) run_case(k);
    // done holds without a new start
    repeat (50) @(negedge clk);
    chk("R10 done holds", int'(done), 1);
    // reset in the middle of a run
    cur = CASES[0];
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (40) @(negedge clk);
    chk("R2 pulse phase entered", int'(vpp), 1);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset vpp/pgm", int'(vpp | pgm), 0);
    chk("R1 mid-run reset done/fail", int'(done | fail | oe), 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk("R1 stays idle", int'(vpp | done | fail), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule